// File: doc/BRIEF.md
# Eviction and Store Write Buffer

This block is a shallow queue between a first-level data cache and a lower-level memory that has a single read/write port. Dirty lines leaving the cache, or stores issued by a write-through cache, are placed in the queue. The cache's miss fill can then go to lower memory at once, without first waiting for the writeback to finish. Queued writes go out later, oldest first, in cycles when the memory port is not carrying a fill read.

The block owns the shared memory port. A fill read from the cache always wins the port. A queued write is offered only when no fill is pending, and it leaves the queue in the cycle the memory grants it. A read miss also probes the queue by address through a combinational lookup port. If the address is queued, the lookup returns the newest data held for it, because lower memory may still hold an older value. A store whose address equals the most recently queued entry overwrites that entry instead of taking a new slot. Writes to other addresses keep their drain order.

Top module: `evict_wbuf`

## Requirements
- R1: After reset the queue is empty: `mem_req` is 0, `enq_ready` is 1 and `lk_hit` is 0.
- R2: Accepted entries drain in arrival order. Each drain is a write shown on the memory port (`mem_req`=1, `mem_we`=1, the oldest entry's address and data), and exactly one entry leaves per cycle with `mem_gnt`=1.
- R3: With 4 entries held (`DEPTH`=4), `enq_ready` is 0 for an address that differs from the newest entry. An enqueue attempted then is dropped: no later drain carries it.
- R4: While `fill_req` is 1, the memory port carries the fill: `mem_req`=1, `mem_we`=0 and `mem_addr`=`fill_addr`. `fill_gnt` follows `mem_gnt`, and no queued entry drains, even with `mem_gnt`=1.
- R5: While `mem_gnt` is 0 (memory busy), no entry drains, and `mem_req` stays 1 as long as entries are held.
- R6: `lk_hit` is 1 in the same cycle that `lk_addr` equals the address of a held entry, and `lk_data` then carries that entry's data. For an address that is not held, `lk_hit` is 0.
- R7: When several held entries match `lk_addr`, `lk_data` carries the data of the one enqueued last.
- R8: An enqueue whose address equals the newest held entry overwrites that entry's data and takes no new slot. This is accepted even when the queue is full, and a single write with the new data later drains.
- R9: An enqueue whose address matches only an older entry, not the newest one, takes a new slot. Both writes drain, in order.
- R10: When the only held entry drains in the same cycle as an enqueue to its address, the enqueue takes a new slot. Both the old data and the new data reach memory, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_addr | input | ADDR_W | Address of the line or word to queue |
| enq_data | input | DATA_W | Data to queue |
| enq_ready | output | 1 | Enqueue accepted this cycle when 1 |
| lk_addr | input | ADDR_W | Read-miss probe address |
| lk_hit | output | 1 | Probe address is held in the queue |
| lk_data | output | DATA_W | Newest queued data for the probe address |
| fill_req | input | 1 | Cache requests a fill read of lower memory |
| fill_addr | input | ADDR_W | Fill read address |
| fill_gnt | output | 1 | Fill read accepted by memory this cycle |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 for a queued write, 0 for a fill read |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | DATA_W | Write data of the draining entry |
| mem_gnt | input | 1 | Memory accepts the request this cycle |

## Verification
The bench builds the block with `DEPTH`=4, `ADDR_W`=12 and `DATA_W`=32. With the small depth the queue fills after four enqueues, so the refusal and the merge into a full queue are both reached in a few cycles. The narrow address lets the bench pick repeated addresses freely. That brings in the newest-match choice, the merge-only-into-newest rule and the race between a drain and an enqueue to the same address. The bench drives `mem_gnt` itself, so it can hold the memory busy or grant a single cycle. This exposes fill priority and the one-entry-per-grant pacing.

// File: rtl/evict_wbuf_pkg.sv
package evict_wbuf_pkg;

    // Who owns the shared lower-memory port in a given cycle.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_FILL  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_owner_e;

endpackage

// File: rtl/wbuf_queue.sv
// Circular storage for queued writes. DEPTH must be a power of two, at least 2.
module wbuf_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           merge,
    input  logic [ADDR_W-1:0]              push_addr,
    input  logic [DATA_W-1:0]              push_data,
    input  logic                           pop,
    output logic [CNT_W-1:0]               count,
    output logic [PTR_W-1:0]               head_ptr,
    output logic [ADDR_W-1:0]              head_addr,
    output logic [DATA_W-1:0]              head_data,
    output logic [ADDR_W-1:0]              young_addr,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]   slot_data
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
    } queue_state_t;

    queue_state_t st_d, st_q;
    logic [PTR_W-1:0] young_idx;
    logic             alloc;

    assign young_idx = st_q.tail - PTR_W'(1);
    assign alloc     = push && !merge;

    always_comb begin
        st_d = st_q;
        if (merge) begin
            st_d.data[young_idx] = push_data;
        end else if (push) begin
            st_d.addr[st_q.tail] = push_addr;
            st_d.data[st_q.tail] = push_data;
            st_d.tail            = st_q.tail + PTR_W'(1);
        end
        if (pop) begin
            st_d.head = st_q.head + PTR_W'(1);
        end
        st_d.count = st_q.count + CNT_W'(alloc) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.count;
    assign head_ptr   = st_q.head;
    assign head_addr  = st_q.addr[st_q.head];
    assign head_data  = st_q.data[st_q.head];
    assign young_addr = st_q.addr[young_idx];
    assign slot_addr  = st_q.addr;
    assign slot_data  = st_q.data;

    // R3: a new slot is never taken while every slot is in use
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (st_q.count != CNT_W'(DEPTH)));

    // R2: nothing leaves an empty queue
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));

    // R8: a merge needs an existing newest entry
    assert_merge_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (st_q.count != '0));

    // R2: occupancy moves by allocations minus drains, one step per cycle
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.count == $past(st_q.count) + CNT_W'($past(alloc)) - CNT_W'($past(pop))));

endmodule

// File: rtl/wbuf_match.sv
// Associative probe: returns the youngest held entry whose address matches.
module wbuf_match #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            lk_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
    input  logic [PTR_W-1:0]             head_ptr,
    input  logic [CNT_W-1:0]             count,
    output logic                         lk_hit,
    output logic [DATA_W-1:0]            lk_data
);

    logic [DEPTH-1:0] addr_eq;

    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign addr_eq[s] = (slot_addr[s] == lk_addr);
    end

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int age = 0; age < DEPTH; age++) begin
            logic [PTR_W-1:0] slot;
            slot = head_ptr + PTR_W'(age);
            if ((CNT_W'(age) < count) && addr_eq[slot]) begin
                lk_hit  = 1'b1;
                lk_data = slot_data[slot];
            end
        end
    end

    // R6: an empty queue never reports a hit
    assert_empty_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !lk_hit);

endmodule

// File: rtl/wbuf_port_arb.sv
// Shares the single lower-memory port: fill reads first, drains in idle slots.
module wbuf_port_arb
    import evict_wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              have_entry,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fill_gnt,
    output logic              drain_fire
);

    port_owner_e owner;

    always_comb begin
        if (fill_req)        owner = PORT_FILL;
        else if (have_entry) owner = PORT_DRAIN;
        else                 owner = PORT_IDLE;
    end

    always_comb begin
        mem_req    = (owner != PORT_IDLE);
        mem_we     = (owner == PORT_DRAIN);
        mem_addr   = (owner == PORT_FILL) ? fill_addr : head_addr;
        mem_wdata  = head_data;
        fill_gnt   = (owner == PORT_FILL) && mem_gnt;
        drain_fire = (owner == PORT_DRAIN) && mem_gnt;
    end

    // R4: a pending fill read keeps every queued write off the port
    assert_fill_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !drain_fire);

    // R5: a drain happens only in a granted write cycle
    assert_drain_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_fire |-> (mem_gnt && mem_req && mem_we));

endmodule

// File: rtl/evict_wbuf.sv
module evict_wbuf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]             count;
    logic [PTR_W-1:0]             head_ptr;
    logic [ADDR_W-1:0]            head_addr;
    logic [DATA_W-1:0]            head_data;
    logic [ADDR_W-1:0]            young_addr;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic                         drain_fire;
    logic                         merge_cand;
    logic                         is_full;
    logic                         push;
    logic                         merge;

    // Merge only into the newest entry, and never into an entry leaving now.
    assign is_full    = (count == CNT_W'(DEPTH));
    assign merge_cand = (count != '0) && (young_addr == enq_addr)
                        && !((count == CNT_W'(1)) && drain_fire);
    assign enq_ready  = !is_full || merge_cand;
    assign push       = enq_valid && enq_ready;
    assign merge      = push && merge_cand;

    wbuf_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .merge      (merge),
        .push_addr  (enq_addr),
        .push_data  (enq_data),
        .pop        (drain_fire),
        .count      (count),
        .head_ptr   (head_ptr),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .young_addr (young_addr),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data)
    );

    wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (lk_addr),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .head_ptr  (head_ptr),
        .count     (count),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data)
    );

    wbuf_port_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_req   (fill_req),
        .fill_addr  (fill_addr),
        .have_entry (count != '0),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .fill_gnt   (fill_gnt),
        .drain_fire (drain_fire)
    );

    // R3: a refused enqueue only happens against a full queue
    assert_refuse_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_ready) |-> is_full);

    // R5: held entries keep the memory port requested
    assert_req_while_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> mem_req);

    // R10: the entry leaving this cycle is never the merge target
    assert_no_merge_on_leaver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && drain_fire) |-> (count > CNT_W'(1)));

endmodule

// File: tb/evict_wbuf_bench.sv
module evict_wbuf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [DATA_W-1:0] enq_data = '0;
    logic              enq_ready;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              fill_req = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              fill_gnt;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_gnt = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [ADDR_W-1:0] rec_addr [64];
    logic [DATA_W-1:0] rec_data [64];
    int rec_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evict_wbuf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_evict_wbuf (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data), .enq_ready(enq_ready),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_gnt(fill_gnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt)
    );

    // Lower-memory model: logs every granted write.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we && mem_gnt && rec_n < 64) begin
            rec_addr[rec_n] = mem_addr;
            rec_data[rec_n] = mem_wdata;
            rec_n++;
        end
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic enq(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        enq_valid = 1'b1;
        enq_addr  = a;
        enq_data  = d;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic drain_all();
        mem_gnt = 1'b1;
        repeat (DEPTH + 2) @(negedge clk);
        mem_gnt = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "mem_req", 64'(mem_req), 64'd0);
        check("R1", "enq_ready", 64'(enq_ready), 64'd1);
        lk_addr = 12'h000;
        #1;
        check("R1", "lk_hit", 64'(lk_hit), 64'd0);
    endtask

    task automatic t_fifo_order();
        int base = rec_n;
        enq(12'h010, 32'h11);
        enq(12'h020, 32'h22);
        enq(12'h030, 32'h33);
        #1;
        check("R2", "mem_req", 64'(mem_req), 64'd1);
        check("R2", "mem_we", 64'(mem_we), 64'd1);
        check("R2", "head addr", 64'(mem_addr), 64'h010);
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        #1;
        check("R2", "one write per grant", 64'(rec_n - base), 64'd1);
        check("R2", "next head addr", 64'(mem_addr), 64'h020);
        drain_all();
        check("R2", "write count", 64'(rec_n - base), 64'd3);
        check("R2", "order 0", 64'(rec_addr[base]), 64'h010);
        check("R2", "order 1", 64'(rec_addr[base+1]), 64'h020);
        check("R2", "order 2 data", 64'(rec_data[base+2]), 64'h33);
    endtask

    task automatic t_full_and_merge();
        int base = rec_n;
        enq(12'h100, 32'hA0);
        enq(12'h101, 32'hA1);
        enq(12'h102, 32'hA2);
        enq(12'h103, 32'hA3);
        enq_addr = 12'h200;
        #1;
        check("R3", "ready when full", 64'(enq_ready), 64'd0);
        enq(12'h200, 32'hDEAD);
        enq_addr = 12'h103;
        #1;
        check("R8", "ready merge when full", 64'(enq_ready), 64'd1);
        enq(12'h103, 32'hBEEF);
        drain_all();
        check("R3", "writes after refusal", 64'(rec_n - base), 64'd4);
        check("R3", "refused addr absent", 64'(rec_addr[base+3]), 64'h103);
        check("R8", "merged data", 64'(rec_data[base+3]), 64'hBEEF);
    endtask

    task automatic t_fill_priority();
        int base = rec_n;
        enq(12'h300, 32'h55);
        enq(12'h301, 32'h66);
        fill_req  = 1'b1;
        fill_addr = 12'h3C0;
        mem_gnt   = 1'b1;
        #1;
        check("R4", "mem_we during fill", 64'(mem_we), 64'd0);
        check("R4", "mem_addr during fill", 64'(mem_addr), 64'h3C0);
        check("R4", "fill_gnt", 64'(fill_gnt), 64'd1);
        repeat (3) @(negedge clk);
        check("R4", "no drain during fill", 64'(rec_n - base), 64'd0);
        fill_req = 1'b0;
        drain_all();
        check("R4", "drain after fill", 64'(rec_n - base), 64'd2);
        check("R4", "first after fill", 64'(rec_addr[base]), 64'h300);
    endtask

    task automatic t_busy();
        int base = rec_n;
        enq(12'h400, 32'h77);
        repeat (5) @(negedge clk);
        #1;
        check("R5", "no drain while busy", 64'(rec_n - base), 64'd0);
        check("R5", "req held while busy", 64'(mem_req), 64'd1);
        drain_all();
        check("R5", "drain once granted", 64'(rec_n - base), 64'd1);
    endtask

    task automatic t_lookup();
        enq(12'h040, 32'hD1);
        enq(12'h050, 32'hD2);
        lk_addr = 12'h050;
        #1;
        check("R6", "hit", 64'(lk_hit), 64'd1);
        check("R6", "data", 64'(lk_data), 64'hD2);
        lk_addr = 12'h060;
        #1;
        check("R6", "miss", 64'(lk_hit), 64'd0);
        drain_all();
    endtask

    task automatic t_youngest();
        int base = rec_n;
        enq(12'h070, 32'hDA);
        enq(12'h080, 32'hDB);
        enq(12'h070, 32'hDC);
        lk_addr = 12'h070;
        #1;
        check("R7", "youngest data", 64'(lk_data), 64'hDC);
        drain_all();
        check("R9", "three writes", 64'(rec_n - base), 64'd3);
        check("R9", "old data first", 64'(rec_data[base]), 64'hDA);
        check("R9", "new data last", 64'(rec_data[base+2]), 64'hDC);
    endtask

    task automatic t_merge();
        int base = rec_n;
        enq(12'h090, 32'hE1);
        enq(12'h090, 32'hE2);
        lk_addr = 12'h090;
        #1;
        check("R8", "lookup after merge", 64'(lk_data), 64'hE2);
        drain_all();
        check("R8", "single write", 64'(rec_n - base), 64'd1);
        check("R8", "write data", 64'(rec_data[base]), 64'hE2);
    endtask

    task automatic t_race();
        int base = rec_n;
        enq(12'h0A0, 32'hF1);
        mem_gnt = 1'b1;
        enq(12'h0A0, 32'hF2);
        repeat (2) @(negedge clk);
        mem_gnt = 1'b0;
        check("R10", "two writes", 64'(rec_n - base), 64'd2);
        check("R10", "old first", 64'(rec_data[base]), 64'hF1);
        check("R10", "new second", 64'(rec_data[base+1]), 64'hF2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo_order();
        t_full_and_merge();
        t_fill_priority();
        t_busy();
        t_lookup();
        t_youngest();
        t_merge();
        t_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule